// File: doc/BRIEF.md
# ATM Cell Delineation Controller

This block decides, for one receive link, whether the incoming byte stream is aligned to ATM cell boundaries. An upstream aligner computes the header check over each candidate 5-byte header. It then pulses `hdr_vld` once per candidate boundary, with `hdr_ok` set when the check matched. The controller walks three named states, HUNT, PRESYNC and SYNC, using the header-check outcomes. While hunting it asks the aligner to slide the boundary by one bit after each failed candidate.

There are six transitions. HUNT→HUNT on a bad check raises a slip request. HUNT→PRESYNC happens on the first good check. PRESYNC→HUNT happens on any bad check. PRESYNC→SYNC happens once enough good checks are counted. SYNC→SYNC covers good checks and short runs of bad ones. SYNC→HUNT happens on a long enough run of bad checks. The thresholds for leaving SYNC (`alpha_thr`, typically 7) and for entering SYNC (`delta_thr`, typically 6) are runtime inputs that all link instances may share. A third threshold, `loss_thr` (typically 360), sets how many failed candidates seen in HUNT raise the loss-of-delineation level. That level is live: it falls by itself once the machine leaves HUNT, so software polls it.

Top module: `cell_delin_ctrl`

## Requirements
- R1: After reset the state output is HUNT and `slip_req` is low. `loss_flag` is also low when `loss_thr` is nonzero. The state encoding is HUNT=2'b00, PRESYNC=2'b01, SYNC=2'b10, and 2'b11 never appears.
- R2: In HUNT, a strobe with `hdr_ok`=0 keeps the state at HUNT. It drives `slip_req` high for exactly the one cycle after that clock edge. A strobe with `hdr_ok`=1 moves to PRESYNC, and its good check is counted as the first correct cell. `slip_req` is never high in any other case.
- R3: In PRESYNC, any strobe with `hdr_ok`=0 returns the machine to HUNT without a slip request.
- R4: In PRESYNC, the machine moves to SYNC on the good check that brings the correct-cell count, including the one counted in HUNT, to `delta_thr`. At least one good check in PRESYNC is always needed.
- R5: In SYNC, the machine returns to HUNT on the bad check that completes a run of `alpha_thr` consecutive bad checks (a value of 0 acts as 1). A good check restarts the run, and shorter runs keep SYNC.
- R6: A cycle with `hdr_vld`=0 changes nothing, whatever `hdr_ok` holds.
- R7: In HUNT, each bad check adds one to a saturating loss count. `loss_flag` is high while the machine is in HUNT and that count is at least `loss_thr`.
- R8: `loss_flag` drops in the same cycle the state leaves HUNT. The loss count is then zero, so a later stay in HUNT counts again from zero.
- R9: Changes to `alpha_thr` and `delta_thr` take effect at the next strobe without reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hdr_vld | input | 1 | One-cycle strobe per candidate cell boundary |
| hdr_ok | input | 1 | Header check of this candidate matched |
| alpha_thr | input | CNT_W | Consecutive bad checks that end SYNC |
| delta_thr | input | CNT_W | Correct-cell count that reaches SYNC |
| loss_thr | input | LOSS_W | Bad checks in HUNT that raise loss_flag |
| slip_req | output | 1 | Request to shift the boundary by one bit |
| dl_state | output | 2 | Current state (HUNT/PRESYNC/SYNC) |
| loss_flag | output | 1 | Live loss-of-delineation level |

## Verification
The hardest situation to reach is a loss flag that is high and must then fall at exactly the edge where the machine leaves HUNT. It must also not return on the next visit to HUNT, until the bad count builds up again from zero. The stimulus uses a small loss threshold and enough bad strobes to raise the flag. A good strobe then leaves HUNT. The machine is driven back through PRESYNC failure, or through SYNC loss with runtime-shortened thresholds. Fewer bad strobes than the threshold follow, so a stale count would show up as a wrong flag.

// File: rtl/cd_pkg.sv
package cd_pkg;
    typedef enum logic [1:0] {
        ST_HUNT    = 2'b00,
        ST_PRESYNC = 2'b01,
        ST_SYNC    = 2'b10
    } cd_state_e;
endpackage

// File: rtl/cd_run_cnt.sv
module cd_run_cnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt_q
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};
    localparam logic [W-1:0] ONE  = W'(1);

    // clear has priority; clear with inc restarts the run at one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= inc ? ONE : '0;
        end else if (inc && cnt_q != MAXV) begin
            cnt_q <= cnt_q + ONE;
        end
    end

    AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == MAXV && inc && !clr) |=> (cnt_q == MAXV)); // R7
endmodule

// File: rtl/cd_fsm.sv
module cd_fsm
    import cd_pkg::*;
#(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strobe,
    input  logic          ok,
    input  logic [CW-1:0] alpha,
    input  logic [CW-1:0] delta,
    input  logic [CW-1:0] good_cnt,
    input  logic [CW-1:0] bad_cnt,
    output cd_state_e     state_q,
    output logic          state_chg,
    output logic          good_inc,
    output logic          bad_inc,
    output logic          bad_clr,
    output logic          loss_inc,
    output logic          slip_q
);
    localparam int EW = CW + 1;

    cd_state_e  nxt;
    logic [EW-1:0] good_plus;
    logic [EW-1:0] bad_plus;

    assign good_plus = {1'b0, good_cnt} + EW'(1);
    assign bad_plus  = {1'b0, bad_cnt} + EW'(1);

    // transition logic
    always_comb begin
        nxt      = state_q;
        good_inc = 1'b0;
        bad_inc  = 1'b0;
        bad_clr  = 1'b0;
        loss_inc = 1'b0;
        unique case (state_q)
            ST_HUNT: begin
                if (strobe) begin
                    if (ok) begin
                        nxt      = ST_PRESYNC;
                        good_inc = 1'b1;
                    end else begin
                        loss_inc = 1'b1;
                    end
                end
            end
            ST_PRESYNC: begin
                if (strobe) begin
                    if (!ok) begin
                        nxt = ST_HUNT;
                    end else if (good_plus >= {1'b0, delta}) begin
                        nxt = ST_SYNC;
                    end else begin
                        good_inc = 1'b1;
                    end
                end
            end
            ST_SYNC: begin
                if (strobe) begin
                    if (ok) begin
                        bad_clr = 1'b1;
                    end else if (bad_plus >= {1'b0, alpha}) begin
                        nxt = ST_HUNT;
                    end else begin
                        bad_inc = 1'b1;
                    end
                end
            end
            default: nxt = ST_HUNT;
        endcase
    end

    assign state_chg = (nxt != state_q);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_HUNT;
        else        state_q <= nxt;
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) slip_q <= 1'b0;
        else        slip_q <= (state_q == ST_HUNT) && strobe && !ok;
    end

    AST_HUNT_BAD_SLIPS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HUNT && strobe && !ok) |=> (slip_q && state_q == ST_HUNT)); // R2
    AST_NO_STRAY_SLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_HUNT || !strobe || ok) |=> !slip_q); // R2
    AST_PRESYNC_BAD_HUNTS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PRESYNC && strobe && !ok) |=> (state_q == ST_HUNT)); // R3
    AST_SYNC_HOLDS_ON_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SYNC && !(strobe && !ok)) |=> (state_q == ST_SYNC)); // R5
    AST_IDLE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> $stable(state_q)); // R6
endmodule

// File: rtl/cell_delin_ctrl.sv
module cell_delin_ctrl
    import cd_pkg::*;
#(
    parameter int CNT_W  = 4,
    parameter int LOSS_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hdr_vld,
    input  logic              hdr_ok,
    input  logic [CNT_W-1:0]  alpha_thr,
    input  logic [CNT_W-1:0]  delta_thr,
    input  logic [LOSS_W-1:0] loss_thr,
    output logic              slip_req,
    output logic [1:0]        dl_state,
    output logic              loss_flag
);
    cd_state_e          state;
    logic               state_chg, good_inc, bad_inc, bad_clr, loss_inc;
    logic [CNT_W-1:0]   good_cnt, bad_cnt;
    logic [LOSS_W-1:0]  loss_cnt;

    cd_fsm #(.CW(CNT_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe    (hdr_vld),
        .ok        (hdr_ok),
        .alpha     (alpha_thr),
        .delta     (delta_thr),
        .good_cnt  (good_cnt),
        .bad_cnt   (bad_cnt),
        .state_q   (state),
        .state_chg (state_chg),
        .good_inc  (good_inc),
        .bad_inc   (bad_inc),
        .bad_clr   (bad_clr),
        .loss_inc  (loss_inc),
        .slip_q    (slip_req)
    );

    // correct-cell run: restarts at one when PRESYNC is entered
    cd_run_cnt #(.W(CNT_W)) u_good (
        .clk(clk), .rst_n(rst_n), .clr(state_chg), .inc(good_inc), .cnt_q(good_cnt)
    );

    // consecutive bad run while in SYNC
    cd_run_cnt #(.W(CNT_W)) u_bad (
        .clk(clk), .rst_n(rst_n), .clr(state_chg || bad_clr), .inc(bad_inc), .cnt_q(bad_cnt)
    );

    // bad candidates seen while hunting
    cd_run_cnt #(.W(LOSS_W)) u_loss (
        .clk(clk), .rst_n(rst_n), .clr(state_chg), .inc(loss_inc), .cnt_q(loss_cnt)
    );

    assign dl_state  = state;
    assign loss_flag = (state == ST_HUNT) && (loss_cnt >= loss_thr);

    AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        dl_state != 2'b11); // R1
    AST_LOSS_ONLY_HUNT: assert property (@(posedge clk) disable iff (!rst_n)
        loss_flag |-> (dl_state == 2'b00)); // R8
    AST_HUNT_NEVER_JUMPS: assert property (@(posedge clk) disable iff (!rst_n)
        (dl_state == 2'b00) |=> (dl_state != 2'b10)); // R4
endmodule

// File: tb/tb_cell_delin_ctrl.sv
module tb_cell_delin_ctrl;
    localparam int CW = 4;
    localparam int LW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hdr_vld = 1'b0;
    logic          hdr_ok = 1'b0;
    logic [CW-1:0] alpha_thr = 4'd7;
    logic [CW-1:0] delta_thr = 4'd6;
    logic [LW-1:0] loss_thr = 10'd5;
    logic          slip_req;
    logic [1:0]    dl_state;
    logic          loss_flag;

    always #10 clk = ~clk;

    cell_delin_ctrl #(.CNT_W(CW), .LOSS_W(LW)) dut (
        .clk(clk), .rst_n(rst_n), .hdr_vld(hdr_vld), .hdr_ok(hdr_ok),
        .alpha_thr(alpha_thr), .delta_thr(delta_thr), .loss_thr(loss_thr),
        .slip_req(slip_req), .dl_state(dl_state), .loss_flag(loss_flag)
    );

    typedef struct {
        logic [1:0] st;
        logic       slip;
        logic       loss;
        string      tag;
    } exp_t;

    exp_t q[$];
    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    // reference model state
    logic [1:0] m_st = 2'b00;
    int m_good = 0, m_bad = 0, m_loss = 0;

    task automatic step(input logic vld, input logic ok, input string tag);
        exp_t e;
        logic slip;
        int a, d;
        @(negedge clk);
        hdr_vld = vld;
        hdr_ok  = ok;
        slip = 1'b0;
        a = (alpha_thr == 0) ? 1 : int'(alpha_thr);
        d = (delta_thr < 2) ? 2 : int'(delta_thr);
        if (vld) begin
            case (m_st)
                2'b00: if (ok) begin m_st = 2'b01; m_good = 1; m_loss = 0; end
                       else begin slip = 1'b1; if (m_loss < 1023) m_loss++; end
                2'b01: if (!ok) begin m_st = 2'b00; m_good = 0; m_loss = 0; end
                       else if (m_good + 1 >= d) begin m_st = 2'b10; m_good = 0; m_bad = 0; end
                       else m_good++;
                default: if (ok) m_bad = 0;
                       else if (m_bad + 1 >= a) begin m_st = 2'b00; m_bad = 0; m_loss = 0; end
                       else m_bad++;
            endcase
        end
        e.st = m_st;
        e.slip = slip;
        e.loss = (m_st == 2'b00) && (m_loss >= int'(loss_thr));
        e.tag = tag;
        q.push_back(e);
    endtask

    task automatic bads(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1'b1, 1'b0, tag);
    endtask

    task automatic goods(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1'b1, 1'b1, tag);
    endtask

    // monitor: compares after each edge
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            compared++;
            if (dl_state !== e.st || slip_req !== e.slip || loss_flag !== e.loss) begin
                mismatched++;
                $display("FAIL %s: got st=%b slip=%b loss=%b, expected st=%b slip=%b loss=%b",
                         e.tag, dl_state, slip_req, loss_flag, e.st, e.slip, e.loss);
            end
        end
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        compared++;
        if (dl_state !== 2'b00 || slip_req !== 1'b0 || loss_flag !== 1'b0) begin
            mismatched++;
            $display("FAIL R1: got st=%b slip=%b loss=%b, expected 00 0 0", dl_state, slip_req, loss_flag);
        end

        bads(3, "R2 hunt slip");
        step(1'b0, 1'b1, "R6 idle ok ignored");
        step(1'b0, 1'b0, "R6 idle");
        step(1'b0, 1'b1, "R2 slip one cycle");
        goods(1, "R2 hunt to presync");
        bads(1, "R3 presync bad");
        bads(6, "R7 loss raise");
        goods(1, "R8 loss drops");
        step(1'b0, 1'b1, "R6 idle presync");
        goods(5, "R4 presync to sync");
        bads(6, "R5 short bad run");
        goods(1, "R5 run restart");
        bads(6, "R5 after restart");
        bads(1, "R5 sync lost");
        bads(4, "R8 loss count restarted");
        alpha_thr = 4'd2;
        delta_thr = 4'd3;
        goods(3, "R9 delta short");
        bads(1, "R9 alpha one bad");
        goods(1, "R9 alpha restart");
        bads(2, "R9 alpha short");
        delta_thr = 4'd0;
        goods(2, "R4 delta min two");
        alpha_thr = 4'd0;
        bads(1, "R5 alpha zero");
        bads(5, "R7 flag at threshold");
        goods(1, "R8 flag clears");
        bads(1, "R3 presync fail");
        bads(4, "R8 fresh count");
        step(1'b0, 1'b0, "R6 tail");
        step(1'b0, 1'b0, "R6 tail");
        while (q.size() > 0) @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule